// File: doc/BRIEF.md
# Dual-Ring Operation Interval Sequencer

This block divides time into a repeating frame of 24 operation intervals of identical length, exactly one of which is active at any moment. A downstream program decoder uses the active strobe to decide which switches and pulse paths to open during that interval.

Two circulating one-hot rings produce the strobes instead of a binary counter and a decoder. The fast ring has 4 stages and the slow ring has 6 stages. Each strobe is the NOR of the active-low outputs of one fast stage and one slow stage.

Every pulse on the tick input moves the fast ring forward one stage. When the fast ring wraps from its last stage to its first, the slow ring also moves forward one stage. Both ring states are brought out so that finer sub-interval gating can be built on the same timebase.

Top module: `interval_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the registered outputs take these values after that edge: `interval_o` = bit 0 only, `fast_o` = 4'b0001 and `slow_o` = 6'b000001.
- R2: `interval_o`, `fast_o` and `slow_o` each have exactly one bit set at every edge after reset.
- R3: When `tick_i` is low at an edge, all three outputs hold their values.
- R4: When `tick_i` is high at an edge, the active interval index advances by one. Index 23 wraps to index 0.
- R5: Bit k of `interval_o` is set exactly when `fast_o` bit (k mod 4) and `slow_o` bit (k div 4) are set. That is, index = slow position × 4 + fast position.
- R6: On each tick, `fast_o` rotates one position toward the higher bit. Bit 3 wraps to bit 0.
- R7: `slow_o` rotates one position toward the higher bit only on a tick taken while `fast_o` bit 3 is set. Bit 5 wraps to bit 0. On any other tick, `slow_o` holds.
- R8: When `tick_i` is held high, every interval stays active for exactly one cycle. The full frame repeats every 24 cycles.
- R9: Reset takes priority over a tick in the same cycle. It returns the block to interval 0 from any position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Advance pulse, one interval step per high cycle |
| interval_o | output | 24 | One-hot operation interval strobes, registered |
| fast_o | output | 4 | Fast ring state, one-hot |
| slow_o | output | 6 | Slow ring state, one-hot |

## Verification
The bench walks more than one full frame tick by tick, so it crosses both the 3-to-0 fast wrap and the 23-to-0 frame wrap. A slow ring that advanced on the wrong fast stage, or that failed to wrap, would show up there as a skipped, repeated or doubled strobe.

Idle gaps between ticks expose a design that free-runs or that advances on the tick's falling side. A burst with the tick held high for a whole frame catches an interval that lasts two cycles or that lags its rings by one cycle.

Asserting reset together with a tick mid-frame catches a reset that loses priority and leaves the block one interval past zero.

// File: rtl/seqtime_pkg.sv
package seqtime_pkg;
  localparam int unsigned DEF_FAST_LEN = 4;
  localparam int unsigned DEF_SLOW_LEN = 6;
endpackage

// File: rtl/seq_ring.sv
module seq_ring #(
  parameter int unsigned LEN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  output logic [LEN-1:0] state_q,
  output logic [LEN-1:0] state_nxt
);
  // rotate toward the higher bit; the top stage feeds back to stage 0
  always_comb begin
    if (adv) state_nxt = {state_q[LEN-2:0], state_q[LEN-1]};
    else     state_nxt = state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LEN'(1);
    else     state_q <= state_nxt;
  end
endmodule

// File: rtl/strobe_matrix.sv
module strobe_matrix #(
  parameter int unsigned FAST_LEN = 4,
  parameter int unsigned SLOW_LEN = 6,
  localparam int unsigned NUM_IV  = FAST_LEN * SLOW_LEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FAST_LEN-1:0] fast_nxt,
  input  logic [SLOW_LEN-1:0] slow_nxt,
  output logic [NUM_IV-1:0]   strobe_q
);
  logic [FAST_LEN-1:0] fast_low;
  logic [SLOW_LEN-1:0] slow_low;
  logic [NUM_IV-1:0]   gate;

  assign fast_low = ~fast_nxt;
  assign slow_low = ~slow_nxt;

  // one NOR per (slow, fast) pair; the strobe is high only when both low-true lines are low
  for (genvar s = 0; s < SLOW_LEN; s++) begin : g_slow
    for (genvar f = 0; f < FAST_LEN; f++) begin : g_fast
      assign gate[s*FAST_LEN + f] = ~(fast_low[f] | slow_low[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= NUM_IV'(1);
    else     strobe_q <= gate;
  end
endmodule

// File: rtl/interval_strobe_gen.sv
module interval_strobe_gen
  import seqtime_pkg::*;
#(
  parameter int unsigned FAST_LEN = DEF_FAST_LEN,
  parameter int unsigned SLOW_LEN = DEF_SLOW_LEN,
  localparam int unsigned NUM_IV  = FAST_LEN * SLOW_LEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  output logic [NUM_IV-1:0]   interval_o,
  output logic [FAST_LEN-1:0] fast_o,
  output logic [SLOW_LEN-1:0] slow_o
);
  logic [FAST_LEN-1:0] fast_q, fast_nxt;
  logic [SLOW_LEN-1:0] slow_q, slow_nxt;
  logic                slow_adv;

  seq_ring #(.LEN(FAST_LEN)) u_fast (
    .clk(clk), .rst(rst), .adv(tick_i),
    .state_q(fast_q), .state_nxt(fast_nxt)
  );

  // the slow ring steps on the tick that carries the fast ring out of its top stage
  assign slow_adv = tick_i & fast_q[FAST_LEN-1];

  seq_ring #(.LEN(SLOW_LEN)) u_slow (
    .clk(clk), .rst(rst), .adv(slow_adv),
    .state_q(slow_q), .state_nxt(slow_nxt)
  );

  // strobes are built from next-state values so they register on the same edge as the rings
  strobe_matrix #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) u_matrix (
    .clk(clk), .rst(rst),
    .fast_nxt(fast_nxt), .slow_nxt(slow_nxt),
    .strobe_q(interval_o)
  );

  assign fast_o = fast_q;
  assign slow_o = slow_q;
endmodule

// File: rtl/interval_strobe_gen_chk.sv
module interval_strobe_gen_chk #(
  parameter int unsigned FAST_LEN = 4,
  parameter int unsigned SLOW_LEN = 6,
  localparam int unsigned NUM_IV  = FAST_LEN * SLOW_LEN
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_i,
  input logic [NUM_IV-1:0]   interval_o,
  input logic [FAST_LEN-1:0] fast_o,
  input logic [SLOW_LEN-1:0] slow_o
);
  logic [NUM_IV-1:0]   prev_iv;
  logic [FAST_LEN-1:0] prev_fast;
  logic [SLOW_LEN-1:0] prev_slow;

  always_ff @(posedge clk) begin
    prev_iv   <= interval_o;
    prev_fast <= fast_o;
    prev_slow <= slow_o;
  end

  // R2
  iv_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(interval_o) == 1);
  // R2
  rings_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(fast_o) == 1) && ($countones(slow_o) == 1));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(interval_o) && $stable(fast_o) && $stable(slow_o)));
  // R4
  iv_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> interval_o == {prev_iv[NUM_IV-2:0], prev_iv[NUM_IV-1]});
  // R6
  fast_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> fast_o == {prev_fast[FAST_LEN-2:0], prev_fast[FAST_LEN-1]});
  // R7
  slow_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && fast_o[FAST_LEN-1]) |=> slow_o == {prev_slow[SLOW_LEN-2:0], prev_slow[SLOW_LEN-1]});
  // R7
  slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !fast_o[FAST_LEN-1]) |=> $stable(slow_o));

  // R5
  for (genvar k = 0; k < NUM_IV; k++) begin : g_map
    iv_map_chk: assert property (@(posedge clk) disable iff (rst)
      interval_o[k] == (fast_o[k % FAST_LEN] && slow_o[k / FAST_LEN]));
  end
endmodule

bind interval_strobe_gen interval_strobe_gen_chk #(
  .FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)
) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i),
  .interval_o(interval_o), .fast_o(fast_o), .slow_o(slow_o)
);

// File: tb/tb_interval_strobe_gen.sv
`timescale 1ns/1ps
module tb_interval_strobe_gen;
  localparam int FL = 4;
  localparam int SL = 6;
  localparam int NI = FL * SL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic [NI-1:0] interval_o;
  logic [FL-1:0] fast_o;
  logic [SL-1:0] slow_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  interval_strobe_gen dut (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .interval_o(interval_o), .fast_o(fast_o), .slow_o(slow_o)
  );

  // expected outputs are derived from index = slow*4 + fast
  task automatic check_idx(input int idx, input string req);
    logic [NI-1:0] e_iv;
    logic [FL-1:0] e_f;
    logic [SL-1:0] e_s;
    e_iv = NI'(1) << idx;
    e_f  = FL'(1) << (idx % FL);
    e_s  = SL'(1) << (idx / FL);
    checks++;
    if (interval_o !== e_iv || fast_o !== e_f || slow_o !== e_s) begin
      fails++;
      $display("FAIL %s: iv=%h fast=%b slow=%b expected iv=%h fast=%b slow=%b",
               req, interval_o, fast_o, slow_o, e_iv, e_f, e_s);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
    check_idx(0, "R1 reset state");
  endtask

  // R3: idle gaps leave the position unchanged
  task automatic t_hold();
    for (int i = 0; i < 5; i++) tick_once();
    repeat (12) @(negedge clk);
    check_idx(5, "R3 hold without tick");
    tick_once();
    repeat (3) @(negedge clk);
    check_idx(6, "R3 hold after single tick");
  endtask

  // R4 R5 R6 R7 R2: single ticks across both wraps
  task automatic t_walk();
    for (int i = 1; i <= 30; i++) begin
      tick_once();
      check_idx(i % NI, "R4/R5/R6/R7 walk");
      checks++;
      if ($countones(interval_o) != 1) begin
        fails++;
        $display("FAIL R2: ones=%0d expected 1", $countones(interval_o));
      end
    end
  endtask

  // R8: tick held high, one cycle per interval
  task automatic t_burst();
    @(negedge clk) tick_i = 1'b1;
    for (int i = 1; i <= NI + 2; i++) begin
      @(negedge clk);
      check_idx(i % NI, "R8 burst");
    end
    tick_i = 1'b0;
  endtask

  // R9: reset wins over a simultaneous tick
  task automatic t_reset_mid();
    for (int i = 0; i < 13; i++) tick_once();
    check_idx(13, "R9 pre-reset position");
    @(negedge clk) begin rst = 1'b1; tick_i = 1'b1; end
    @(negedge clk) begin rst = 1'b0; tick_i = 1'b0; end
    check_idx(0, "R9 reset beats tick");
  endtask

  initial begin
    t_reset();
    t_hold();
    t_reset();
    t_walk();
    t_reset();
    t_burst();
    t_reset();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule